// File: doc/BRIEF.md
# Trigger Link Frame Receiver

This block sits behind a trigger data link that delivers one 48-bit word per valid cycle. Of each word, only the low 36 bits matter: a 32-bit payload plus four control bits that mark the start of a frame, select its length, tag the word as a crossing/turn count word, and carry an even parity bit. The block rebuilds frames from the stream. It checks that every frame holds exactly the number of words its header word declared, which is either 8 or 10. It checks parity on every received word.

Payload words that pass all checks go into a small first-word-fall-through FIFO. Count words that pass all checks do not enter the FIFO. Instead they update a bunch-crossing register and a turn register. For test use, three sticky error flags record parity faults, frames cut short by an early header, and words that overrun a complete frame. Three saturating counters count the same three events. A single clear input resets the flags and the counters. The block assumes the words are already in its own clock domain.

Top module: `link_frame_rx`

## Requirements
- R1: Word layout: bits [31:0] are the payload, bit 32 is start-of-frame, bit 33 is length select (1 means 10 words, 0 means 8 words), bit 34 marks a crossing word, and bit 35 is parity. Bits [47:36] are ignored. A valid word whose XOR over bits [35:0] is 1 has a parity fault. A parity fault sets the parity flag after the clock edge on which the word is sampled.
- R2: The 16-bit parity counter adds one for each faulty word and holds at 65535.
- R3: A valid word with bit 32 set opens a frame whose length is taken from its own bit 33. That word, and the valid words that follow it up to the declared count, are accepted. A word that fails parity still occupies its place in the frame.
- R4: A start-of-frame word that arrives while a frame is still open sets the short-frame flag and increments the short-frame counter (16-bit, saturating). That word then opens the next frame.
- R5: The first valid word without bit 32 after a complete frame sets the long-frame flag and increments the long-frame counter (16-bit, saturating). Further valid words without bit 32 are discarded without any error until a start-of-frame word arrives. The same silent discard applies after reset.
- R6: An accepted, parity-clean word with bit 34 set loads payload[15:0] into the crossing count and payload[31:16] into the turn count. Such a word never enters the FIFO.
- R7: An accepted, parity-clean word with bit 34 clear is written to the FIFO. Words that are discarded or fail parity are never written.
- R8: rdValid is high whenever the FIFO holds data, and rdData shows the oldest entry. Asserting rdEn while rdValid is high removes that entry. rdEn has no effect while the FIFO is empty.
- R9: When the FIFO is full, a write is dropped unless a read happens on the same cycle, in which case both take place.
- R10: clearErr zeroes all three flags and all three counters. An error detected on the same cycle is recorded after the clear, leaving its flag at 1 and its counter at 1.
- R11: After reset the FIFO is empty, all flags, counters and count registers are zero, and no frame is open.
- R12: While linkValid is low the input word has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkValid | input | 1 | Received word is valid this cycle |
| linkWord | input | 48 | Received link word |
| clearErr | input | 1 | Clears error flags and counters |
| rdEn | input | 1 | Pops the oldest FIFO entry |
| rdData | output | 32 | Oldest FIFO entry |
| rdValid | output | 1 | FIFO not empty |
| bxCount | output | 16 | Last latched bunch-crossing count |
| turnCount | output | 16 | Last latched turn count |
| parityErrFlag | output | 1 | Sticky parity fault flag |
| shortErrFlag | output | 1 | Sticky short-frame flag |
| longErrFlag | output | 1 | Sticky long-frame flag |
| parityErrCnt | output | 16 | Saturating parity fault count |
| shortErrCnt | output | 16 | Saturating short-frame count |
| longErrCnt | output | 16 | Saturating long-frame count |

## Verification
Two pairs of events can land on the same cycle. The first is a clear together with a fresh error. The bench drives clearErr on the same cycle as a word with bad parity, and again on the same cycle as an early header word. In both cases it expects the flag at 1 and the counter at exactly 1 afterward. The second is a FIFO write together with a read while the FIFO is full. The bench fills the FIFO with no reads, then keeps reads and writes running together. The behavioural queue model sets the expected contents, and every FIFO output is compared on every clock.

// File: rtl/rxlink_pkg.sv
package rxlink_pkg;
  localparam int SOF_BIT    = 32;
  localparam int LEN_BIT    = 33;
  localparam int XING_BIT   = 34;
  localparam int PAR_BIT    = 35;
  localparam int PAYLOAD_W  = 32;
  localparam int USED_W     = 36;
  localparam int NUM_ERR    = 3;
  localparam int ERR_PARITY = 0;
  localparam int ERR_SHORT  = 1;
  localparam int ERR_LONG   = 2;

  typedef struct packed {
    logic push;
    logic latchXing;
    logic longErr;
    logic shortErr;
    logic parityErr;
  } rxStrobe_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import rxlink_pkg::*;
#(
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [USED_W-1:0] wordBits,
  output rxStrobe_t         strobes
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_LEN);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_LEN);

  logic          inFrame;
  logic          lenLong;
  logic          armed;
  logic [CW-1:0] wordCnt;
  logic [CW-1:0] frameLen;
  logic          parityBad, isSof, isXing;
  logic          accept, startNew, advance;

  assign parityBad = ^wordBits;
  assign isSof     = wordBits[SOF_BIT];
  assign isXing    = wordBits[XING_BIT];
  assign frameLen  = lenLong ? LONG_C : SHORT_C;

  always_comb begin
    strobes  = '0;
    accept   = 1'b0;
    startNew = 1'b0;
    advance  = 1'b0;
    if (wordValid) begin
      strobes.parityErr = parityBad;
      if (isSof) begin
        startNew         = 1'b1;
        accept           = 1'b1;
        strobes.shortErr = inFrame;
      end else if (inFrame) begin
        advance = 1'b1;
        accept  = 1'b1;
      end else begin
        strobes.longErr = armed;
      end
      strobes.push      = accept && !parityBad && !isXing;
      strobes.latchXing = accept && !parityBad && isXing;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      lenLong <= 1'b0;
      armed   <= 1'b0;
      wordCnt <= '0;
    end else if (startNew) begin
      inFrame <= 1'b1;
      lenLong <= wordBits[LEN_BIT];
      armed   <= 1'b0;
      wordCnt <= CW'(1);
    end else if (advance) begin
      if (wordCnt + CW'(1) == frameLen) begin
        inFrame <= 1'b0;
        armed   <= 1'b1;
        wordCnt <= '0;
      end else begin
        wordCnt <= wordCnt + CW'(1);
      end
    end else if (wordValid) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rxlink_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxStrobe_t                strobes,
  input  logic [PAYLOAD_W-1:0]     payload,
  input  logic                     clearErr,
  input  logic                     rdEn,
  output logic [PAYLOAD_W-1:0]     rdData,
  output logic                     rdValid,
  output logic [PAYLOAD_W/2-1:0]   bxCount,
  output logic [PAYLOAD_W/2-1:0]   turnCount,
  output logic [NUM_ERR-1:0]       errFlags,
  output logic [NUM_ERR*CNT_W-1:0] errCounts
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int HALF  = PAYLOAD_W / 2;
  localparam logic [PTR_W:0]   FULL_C  = (PTR_W + 1)'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PAYLOAD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [PTR_W:0]       fill;
  logic                 popFire, pushFire;
  logic [NUM_ERR-1:0]   errIn;

  assign rdValid  = (fill != '0);
  assign rdData   = mem[rdPtr];
  assign popFire  = rdEn && rdValid;
  assign pushFire = strobes.push && ((fill != FULL_C) || popFire);

  always_ff @(posedge clk) begin
    if (pushFire) mem[wrPtr] <= payload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (pushFire) wrPtr <= wrPtr + PTR_W'(1);
      if (popFire)  rdPtr <= rdPtr + PTR_W'(1);
      case ({pushFire, popFire})
        2'b10:   fill <= fill + (PTR_W + 1)'(1);
        2'b01:   fill <= fill - (PTR_W + 1)'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bxCount   <= '0;
      turnCount <= '0;
    end else if (strobes.latchXing) begin
      bxCount   <= payload[HALF-1:0];
      turnCount <= payload[PAYLOAD_W-1:HALF];
    end
  end

  assign errIn[ERR_PARITY] = strobes.parityErr;
  assign errIn[ERR_SHORT]  = strobes.shortErr;
  assign errIn[ERR_LONG]   = strobes.longErr;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    logic [CNT_W-1:0] cnt;
    logic             flag;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        flag <= 1'b0;
      end else if (clearErr) begin
        cnt  <= errIn[i] ? CNT_W'(1) : '0;
        flag <= errIn[i];
      end else if (errIn[i]) begin
        flag <= 1'b1;
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
    end
    assign errFlags[i] = flag;
    assign errCounts[i*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/link_frame_rx.sv
module link_frame_rx
  import rxlink_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16,
  parameter int SHORT_LEN  = 8,
  parameter int LONG_LEN   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkValid,
  input  logic [47:0]      linkWord,
  input  logic             clearErr,
  input  logic             rdEn,
  output logic [31:0]      rdData,
  output logic             rdValid,
  output logic [15:0]      bxCount,
  output logic [15:0]      turnCount,
  output logic             parityErrFlag,
  output logic             shortErrFlag,
  output logic             longErrFlag,
  output logic [CNT_W-1:0] parityErrCnt,
  output logic [CNT_W-1:0] shortErrCnt,
  output logic [CNT_W-1:0] longErrCnt
);
  rxStrobe_t                strobes;
  logic [NUM_ERR-1:0]       errFlags;
  logic [NUM_ERR*CNT_W-1:0] errCounts;
  logic                     unusedHighBits;

  assign unusedHighBits = ^linkWord[47:USED_W];

  frame_ctrl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wordValid(linkValid),
    .wordBits (linkWord[USED_W-1:0]),
    .strobes  (strobes)
  );

  rx_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .payload  (linkWord[PAYLOAD_W-1:0]),
    .clearErr (clearErr),
    .rdEn     (rdEn),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .bxCount  (bxCount),
    .turnCount(turnCount),
    .errFlags (errFlags),
    .errCounts(errCounts)
  );

  assign parityErrFlag = errFlags[ERR_PARITY];
  assign shortErrFlag  = errFlags[ERR_SHORT];
  assign longErrFlag   = errFlags[ERR_LONG];
  assign parityErrCnt  = errCounts[ERR_PARITY*CNT_W +: CNT_W];
  assign shortErrCnt   = errCounts[ERR_SHORT*CNT_W +: CNT_W];
  assign longErrCnt    = errCounts[ERR_LONG*CNT_W +: CNT_W];
endmodule

// File: rtl/link_frame_rx_chk.sv
module link_frame_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkValid,
  input logic [47:0]      linkWord,
  input logic             clearErr,
  input logic             parityErrFlag,
  input logic             shortErrFlag,
  input logic             longErrFlag,
  input logic [CNT_W-1:0] parityErrCnt,
  input logic [15:0]      bxCount,
  input logic [15:0]      turnCount
);
  logic badWord;
  assign badWord = linkValid && (^linkWord[35:0]);

  assert_parity_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    badWord |=> parityErrFlag);

  assert_flag_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    (parityErrFlag && !clearErr) |=> parityErrFlag);

  assert_cnt_monotonic_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clearErr |=> (parityErrCnt >= $past(parityErrCnt)));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clearErr && !badWord) |=> (!parityErrFlag && parityErrCnt == '0));

  assert_xing_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(linkValid && linkWord[34]) |=> ($stable(bxCount) && $stable(turnCount)));

  assert_idle_no_effect_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!linkValid && !clearErr) |=>
      $stable({parityErrFlag, shortErrFlag, longErrFlag, parityErrCnt}));
endmodule

bind link_frame_rx link_frame_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .linkValid    (linkValid),
  .linkWord     (linkWord),
  .clearErr     (clearErr),
  .parityErrFlag(parityErrFlag),
  .shortErrFlag (shortErrFlag),
  .longErrFlag  (longErrFlag),
  .parityErrCnt (parityErrCnt),
  .bxCount      (bxCount),
  .turnCount    (turnCount)
);

// File: tb/tb_link_frame_rx.sv
module tb_link_frame_rx;
  localparam int DEPTH = 8;
  localparam int CMAX  = 65535;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, linkValid, clearErr, rdEn;
  logic [47:0] linkWord;
  logic [31:0] rdData;
  logic        rdValid, parityErrFlag, shortErrFlag, longErrFlag;
  logic [15:0] bxCount, turnCount, parityErrCnt, shortErrCnt, longErrCnt;

  link_frame_rx dut (
    .clk(clk), .rstN(rstN), .linkValid(linkValid), .linkWord(linkWord),
    .clearErr(clearErr), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .bxCount(bxCount), .turnCount(turnCount),
    .parityErrFlag(parityErrFlag), .shortErrFlag(shortErrFlag),
    .longErrFlag(longErrFlag), .parityErrCnt(parityErrCnt),
    .shortErrCnt(shortErrCnt), .longErrCnt(longErrCnt)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] q[$];
  int mBx = 0, mTurn = 0;
  int fPar = 0, fShort = 0, fLong = 0;
  int cPar = 0, cShort = 0, cLong = 0;
  int open = 0, seen = 0, want = 0, armed = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R8 rdValid", 32'(rdValid), 32'(q.size() > 0));
    if (q.size() > 0) chk("R3 R7 R9 rdData", rdData, q[0]);
    chk("R6 bxCount", 32'(bxCount), 32'(mBx));
    chk("R6 turnCount", 32'(turnCount), 32'(mTurn));
    chk("R1 parity flag", 32'(parityErrFlag), 32'(fPar));
    chk("R2 parity count", 32'(parityErrCnt), 32'(cPar));
    chk("R4 short flag", 32'(shortErrFlag), 32'(fShort));
    chk("R4 short count", 32'(shortErrCnt), 32'(cShort));
    chk("R5 long flag", 32'(longErrFlag), 32'(fLong));
    chk("R5 long count", 32'(longErrCnt), 32'(cLong));
  endtask

  function automatic int sat(int v);
    return (v < CMAX) ? v + 1 : CMAX;
  endfunction

  task automatic modelStep(logic v, logic [47:0] w, logic clr, logic rd);
    bit popping, bad, acc;
    int sizeBefore;
    sizeBefore = q.size();
    popping = rd && sizeBefore > 0;
    if (clr) begin
      fPar = 0; fShort = 0; fLong = 0; cPar = 0; cShort = 0; cLong = 0;
    end
    acc = 0;
    bad = ^w[35:0];
    if (v) begin
      if (bad) begin fPar = 1; cPar = sat(cPar); end
      if (w[32]) begin
        if (open != 0) begin fShort = 1; cShort = sat(cShort); end
        open = 1; seen = 1; want = w[33] ? 10 : 8; armed = 0; acc = 1;
      end else if (open != 0) begin
        seen++; acc = 1;
        if (seen == want) begin open = 0; armed = 1; end
      end else begin
        if (armed != 0) begin fLong = 1; cLong = sat(cLong); end
        armed = 0;
      end
    end
    if (popping) void'(q.pop_front());
    if (acc && !bad) begin
      if (w[34]) begin
        mBx = int'(w[15:0]); mTurn = int'(w[31:16]);
      end else if (sizeBefore < DEPTH || popping) begin
        q.push_back(w[31:0]);
      end
    end
  endtask

  task automatic step(logic v, logic [47:0] w, logic clr, logic rd);
    @(negedge clk);
    compareAll();
    linkValid = v; linkWord = w; clearErr = clr; rdEn = rd;
    modelStep(v, w, clr, rd);
  endtask

  function automatic logic [47:0] mkWord(logic [31:0] pl, logic sof, logic len10,
                                         logic xing, logic badPar);
    logic [47:0] w;
    w = {12'hA5C, 4'b0, pl};
    w[32] = sof; w[33] = len10; w[34] = xing;
    w[35] = (^w[34:0]) ^ badPar;
    return w;
  endfunction

  task automatic frame(logic len10, int n, logic [31:0] base, logic rd);
    for (int i = 0; i < n; i++)
      step(1'b1, mkWord(base + 32'(i), i == 0, len10, 1'b0, 1'b0), 1'b0, rd);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired before the run ended");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; linkValid = 1'b0; linkWord = '0; clearErr = 1'b0; rdEn = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 rdValid", 32'(rdValid), 32'd0);
    chk("R11 flags", 32'({parityErrFlag, shortErrFlag, longErrFlag}), 32'd0);
    chk("R11 counters", 32'(parityErrCnt | shortErrCnt | longErrCnt), 32'd0);
    chk("R11 bx/turn", {turnCount, bxCount}, 32'd0);
    rstN = 1'b1;

    // R5: words before any header are dropped silently; R8: read on empty ignored
    for (int i = 0; i < 3; i++) step(1'b1, mkWord(32'h100 + 32'(i), 0, 0, 0, 0), 0, 1);

    // R3 R6 R7: 8-word frame with a crossing word in slot 2
    step(1'b1, mkWord(32'h1000, 1, 0, 0, 0), 0, 0);
    step(1'b1, mkWord(32'hBEEF1234, 0, 0, 1, 0), 0, 0);
    for (int i = 0; i < 6; i++) step(1'b1, mkWord(32'h1010 + 32'(i), 0, 0, 0, 0), 0, 0);
    // R9: 10-word frame fills the FIFO, then writes run alongside reads
    frame(1'b1, 4, 32'h2000, 1'b0);
    for (int i = 4; i < 10; i++) step(1'b1, mkWord(32'h2000 + 32'(i), 0, 1, 0, 0), 0, 1);
    for (int i = 0; i < 10; i++) step(1'b0, '0, 0, 1);

    // R4: header arrives after 4 words of a 10-word frame
    frame(1'b1, 4, 32'h3000, 1'b1);
    frame(1'b0, 8, 32'h3100, 1'b1);
    // R5: overrun after a complete frame, then resume
    for (int i = 0; i < 3; i++) step(1'b1, mkWord(32'h3200 + 32'(i), 0, 0, 0, 0), 0, 1);
    frame(1'b0, 8, 32'h3300, 1'b1);

    // R1 R6: bad parity data and crossing words inside a frame
    step(1'b1, mkWord(32'h4000, 1, 0, 0, 0), 0, 1);
    step(1'b1, mkWord(32'h4001, 0, 0, 0, 1), 0, 1);
    step(1'b1, mkWord(32'h55556666, 0, 0, 1, 1), 0, 1);
    for (int i = 0; i < 5; i++) step(1'b1, mkWord(32'h4010 + 32'(i), 0, 0, 0, 0), 0, 1);

    // R10: clear alone, then clear together with a parity fault
    step(1'b0, '0, 1, 1);
    step(1'b1, mkWord(32'h5000, 1, 0, 0, 1), 1, 1);
    step(1'b0, '0, 0, 1);
    chk("R10 parity flag after clear+fault", 32'(parityErrFlag), 32'd1);
    chk("R10 parity count after clear+fault", 32'(parityErrCnt), 32'd1);
    // R10: clear together with a short-frame event
    step(1'b1, mkWord(32'h5100, 1, 0, 0, 0), 1, 1);
    step(1'b0, '0, 0, 1);
    chk("R10 short count after clear+event", 32'(shortErrCnt), 32'd1);

    // R12: idle cycles carrying a header with bad parity change nothing
    for (int i = 0; i < 4; i++) step(1'b0, mkWord(32'h6000, 1, 1, 1, 1), 0, 0);
    for (int i = 0; i < 7; i++) step(1'b1, mkWord(32'h6100 + 32'(i), 0, 0, 0, 0), 0, 1);
    for (int i = 0; i < 10; i++) step(1'b0, '0, 0, 1);

    // R2: parity counter saturation
    for (int i = 0; i < CMAX + 5; i++) step(1'b1, mkWord(32'h7000, 0, 0, 0, 1), 0, 0);
    step(1'b0, '0, 0, 0);
    chk("R2 parity count saturated", 32'(parityErrCnt), 32'(CMAX));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule